// File: doc/BRIEF.md
# Serial Clock-Count Write Guard

This block sits beside the instruction decoder of a serial non-volatile memory. Electrical noise on the serial clock line can add pulses that shift the address and data bits of an instruction. The guard counts qualified serial clock rising edges from the edge that samples the start bit up to the falling edge of chip select. When chip select falls, it allows a pending modifying instruction only if that count equals the frame length the instruction should have in the current organisation.

All inputs are one-cycle strobes or levels in the system clock domain. The decoder supplies the instruction class and the organisation bit. The guard answers with a one-cycle execute permit or a one-cycle reject, registered one cycle after the chip-select fall strobe. Reads and the enable/disable commands bypass the guard and produce neither pulse.

Top module: `sclk_count_guard`

## Requirements
- R1: After reset both `exec_permit` and `exec_reject` are low and the count is 0. A chip-select fall with a guarded class and no start seen gives a reject.
- R2: The `start_seen` strobe comes in the same cycle as the `sck_rise` that sampled the start bit. It sets the count to 1. Each later `sck_rise` adds 1. Edges before a start, or after a chip-select fall, are not counted.
- R3: A write (`instr_cls` = 3'd1) in byte organisation (`org_x16` = 0) gives a permit exactly when the count is 20.
- R4: A write in word organisation (`org_x16` = 1) gives a permit exactly when the count is 27.
- R5: Erase (3'd2) and erase-all (3'd3) give a permit exactly when the count is 12 in byte organisation and 11 in word organisation.
- R6: Write-all (3'd4) gives a permit exactly when the count is 20 in byte organisation and 27 in word organisation.
- R7: For a guarded class, any other count gives `exec_reject` and no permit.
- R8: Classes 3'd0, 3'd5, 3'd6 and 3'd7 (read, enable, disable, unused) produce neither pulse, whatever the count.
- R9: The count saturates at 2^CNT_W-1 and never wraps. With CNT_W = 5, a burst of 59 edges cannot look like 27.
- R10: `cs_rise` clears the count and stops counting until the next start. A `start_seen` in the same cycle as `cs_rise` takes priority and loads 1.
- R11: An `sck_rise` in the same cycle as `cs_fall` is included in the compared count.
- R12: Permit and reject are each one cycle wide, never high together, and appear in the cycle after `cs_fall`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sck_rise | input | 1 | Strobe: serial clock rising edge seen |
| cs_rise | input | 1 | Strobe: chip select went high |
| cs_fall | input | 1 | Strobe: chip select went low |
| start_seen | input | 1 | Strobe: start bit sampled on this edge |
| instr_cls | input | 3 | Decoded instruction class (encodings in R3-R8 text) |
| org_x16 | input | 1 | 1 = word organisation, 0 = byte organisation |
| exec_permit | output | 1 | One-cycle execute permit |
| exec_reject | output | 1 | One-cycle length-mismatch reject |

## Verification
The last serial clock edge of a frame and the chip-select fall can arrive in the same system cycle. The verdict must then include that edge. The bench provokes this by merging the final `sck_rise` into the `cs_fall` cycle, both on exact-length frames and on frames one edge short, and expects permit and reject to follow the total count. The same pattern is repeated for a start strobe that coincides with the chip-select rise, where the load of 1 must take priority over the clear.

// File: rtl/ckg_pkg.sv
package ckg_pkg;

  typedef enum logic [2:0] {
    CLS_NONE      = 3'd0,
    CLS_WRITE     = 3'd1,
    CLS_ERASE     = 3'd2,
    CLS_ERASE_ALL = 3'd3,
    CLS_WRITE_ALL = 3'd4
  } instr_cls_e;

  // True for classes that modify the array and so need a length check.
  function automatic logic is_guarded(input logic [2:0] cls);
    return (cls == CLS_WRITE) || (cls == CLS_ERASE) ||
           (cls == CLS_ERASE_ALL) || (cls == CLS_WRITE_ALL);
  endfunction

  // Expected number of serial clock edges from start bit to chip-select fall.
  function automatic int frame_len(input logic [2:0] cls, input logic org16,
                                   input int op_bits, input int adr8, input int adr16,
                                   input int dat8, input int dat16);
    int hdr;
    int pay;
    hdr = 1 + op_bits + (org16 ? adr16 : adr8);
    pay = org16 ? dat16 : dat8;
    case (cls)
      CLS_WRITE, CLS_WRITE_ALL: return hdr + pay;
      CLS_ERASE, CLS_ERASE_ALL: return hdr;
      default:                  return 0;
    endcase
  endfunction

endpackage

// File: rtl/ckg_pulse_counter.sv
module ckg_pulse_counter #(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sck_rise,
  input  logic             start_seen,
  input  logic             cs_rise,
  input  logic             cs_fall,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] cnt_eff,
  output logic             armed_q
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  function automatic logic [CNT_W-1:0] sat_inc(input logic [CNT_W-1:0] v);
    return (v == CNT_MAX) ? v : v + CNT_ONE;
  endfunction

  logic bump;
  assign bump = armed_q && sck_rise;

  // Count value including any edge in this cycle; the verdict uses it.
  always_comb begin
    if (start_seen)  cnt_eff = CNT_ONE;
    else if (bump)   cnt_eff = sat_inc(cnt_q);
    else             cnt_eff = cnt_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
    end else if (start_seen) begin
      cnt_q   <= CNT_ONE;
      armed_q <= 1'b1;
    end else if (cs_rise) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
    end else begin
      cnt_q <= cnt_eff;
      if (cs_fall) armed_q <= 1'b0;
    end
  end

  AST_SAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == CNT_MAX && sck_rise && !start_seen && !cs_rise) |=> (cnt_q == CNT_MAX)); // R9
  AST_START_LOADS_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    start_seen |=> (cnt_q == CNT_ONE && armed_q)); // R2
  AST_RISE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_rise && !start_seen) |=> (cnt_q == '0 && !armed_q)); // R10
  AST_IDLE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed_q && !start_seen && !cs_rise) |=> $stable(cnt_q)); // R2

endmodule

// File: rtl/ckg_verdict.sv
module ckg_verdict
  import ckg_pkg::*;
#(
  parameter int CNT_W   = 5,
  parameter int OP_BITS = 2,
  parameter int ADR8    = 9,
  parameter int ADR16   = 8,
  parameter int DAT8    = 8,
  parameter int DAT16   = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_fall,
  input  logic [2:0]       instr_cls,
  input  logic             org_x16,
  input  logic [CNT_W-1:0] cnt_eff,
  output logic             permit_q,
  output logic             reject_q
);
  logic guarded;
  int   want_len;
  logic len_ok;

  assign guarded  = is_guarded(instr_cls);
  assign want_len = frame_len(instr_cls, org_x16, OP_BITS, ADR8, ADR16, DAT8, DAT16);
  assign len_ok   = (int'(cnt_eff) == want_len);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      permit_q <= 1'b0;
      reject_q <= 1'b0;
    end else begin
      permit_q <= cs_fall && guarded && len_ok;
      reject_q <= cs_fall && guarded && !len_ok;
    end
  end

  AST_ONE_VERDICT: assert property (@(posedge clk) disable iff (!rst_n)
    !(permit_q && reject_q)); // R12
  AST_VERDICT_FROM_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    (permit_q || reject_q) |-> $past(cs_fall)); // R12
  AST_BYPASS_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_fall && !guarded) |=> (!permit_q && !reject_q)); // R8
  AST_GUARDED_ANSWERS: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_fall && guarded) |=> (permit_q || reject_q)); // R7
  AST_PULSE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    ((permit_q || reject_q) && !cs_fall) |=> (!permit_q && !reject_q)); // R12

endmodule

// File: rtl/sclk_count_guard.sv
module sclk_count_guard #(
  parameter int CNT_W   = 5,
  parameter int OP_BITS = 2,
  parameter int ADR8    = 9,
  parameter int ADR16   = 8,
  parameter int DAT8    = 8,
  parameter int DAT16   = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sck_rise,
  input  logic       cs_rise,
  input  logic       cs_fall,
  input  logic       start_seen,
  input  logic [2:0] instr_cls,
  input  logic       org_x16,
  output logic       exec_permit,
  output logic       exec_reject
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_eff;
  logic             armed_q;

  ckg_pulse_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .sck_rise   (sck_rise),
    .start_seen (start_seen),
    .cs_rise    (cs_rise),
    .cs_fall    (cs_fall),
    .cnt_q      (cnt_q),
    .cnt_eff    (cnt_eff),
    .armed_q    (armed_q)
  );

  ckg_verdict #(
    .CNT_W(CNT_W), .OP_BITS(OP_BITS), .ADR8(ADR8), .ADR16(ADR16),
    .DAT8(DAT8), .DAT16(DAT16)
  ) u_vdt (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_fall   (cs_fall),
    .instr_cls (instr_cls),
    .org_x16   (org_x16),
    .cnt_eff   (cnt_eff),
    .permit_q  (exec_permit),
    .reject_q  (exec_reject)
  );

  AST_EDGE_ON_FALL_COUNTS: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && sck_rise && cs_fall && !start_seen && !cs_rise) |=> (cnt_q == $past(cnt_eff))); // R11

endmodule

// File: tb/sclk_count_guard_test.sv
module sclk_count_guard_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sck_rise = 1'b0;
  logic       cs_rise = 1'b0;
  logic       cs_fall = 1'b0;
  logic       start_seen = 1'b0;
  logic [2:0] instr_cls = 3'd0;
  logic       org_x16 = 1'b0;
  logic       exec_permit;
  logic       exec_reject;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #2 clk = ~clk;

  sclk_count_guard uut (
    .clk(clk), .rst_n(rst_n), .sck_rise(sck_rise), .cs_rise(cs_rise),
    .cs_fall(cs_fall), .start_seen(start_seen), .instr_cls(instr_cls),
    .org_x16(org_x16), .exec_permit(exec_permit), .exec_reject(exec_reject)
  );

  // Expected {permit, reject} from the requirement tables.
  function automatic logic [1:0] expect_out(input logic [2:0] c, input logic o, input int n);
    int cnt;
    int want;
    cnt = (n > 31) ? 31 : n;  // R9 saturation at 2^5-1
    case (c)
      3'd1, 3'd4: want = o ? 27 : 20;  // R3 R4 R6
      3'd2, 3'd3: want = o ? 11 : 12;  // R5
      default:    return 2'b00;        // R8
    endcase
    return (cnt == want) ? 2'b10 : 2'b01;  // R7
  endfunction

  task automatic chk(input string tag, input logic [1:0] act, input logic [1:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual {permit,reject}=%b expected %b", tag, act, exp);
    end
  endtask

  task automatic drive(input logic s, input logic r, input logic f, input logic st);
    sck_rise = s; cs_rise = r; cs_fall = f; start_seen = st;
    @(negedge clk);
  endtask

  // One framed instruction of n counted edges (start edge included).
  task automatic txn(input string tag, input logic [2:0] c, input logic o, input int n,
                     input bit merge, input bit st_rise, input int pre, input bit gaps);
    instr_cls = c; org_x16 = o;
    if (!st_rise) drive(1'b0, 1'b1, 1'b0, 1'b0);
    repeat (pre) drive(1'b1, 1'b0, 1'b0, 1'b0);
    drive(1'b1, st_rise, 1'b0, 1'b1);
    for (int i = 1; i < n; i++) begin
      if (merge && i == n - 1) drive(1'b1, 1'b0, 1'b1, 1'b0);
      else begin
        drive(1'b1, 1'b0, 1'b0, 1'b0);
        if (gaps && $urandom_range(0, 3) == 0) drive(1'b0, 1'b0, 1'b0, 1'b0);
      end
    end
    if (!(merge && n > 1)) drive(1'b0, 1'b0, 1'b1, 1'b0);
    chk(tag, {exec_permit, exec_reject}, expect_out(c, o, n));
    drive(1'b0, 1'b0, 1'b0, 1'b0);
    chk({tag, " R12 pulse width"}, {exec_permit, exec_reject}, 2'b00);
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20250611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk("R1 reset outputs", {exec_permit, exec_reject}, 2'b00);
    instr_cls = 3'd1;
    drive(1'b0, 1'b0, 1'b1, 1'b0);
    chk("R1 fall without start", {exec_permit, exec_reject}, 2'b01);
    drive(1'b0, 1'b0, 1'b0, 1'b0);

    txn("R3 write x8 20",  3'd1, 1'b0, 20, 0, 0, 0, 0);
    txn("R7 write x8 19",  3'd1, 1'b0, 19, 0, 0, 0, 0);
    txn("R7 write x8 21",  3'd1, 1'b0, 21, 0, 0, 0, 0);
    txn("R4 write x16 27", 3'd1, 1'b1, 27, 0, 0, 0, 1);
    txn("R7 write x16 26", 3'd1, 1'b1, 26, 0, 0, 0, 0);
    txn("R7 write x16 20", 3'd1, 1'b1, 20, 0, 0, 0, 0);
    txn("R5 erase x8 12",  3'd2, 1'b0, 12, 0, 0, 0, 0);
    txn("R5 erase x16 11", 3'd2, 1'b1, 11, 0, 0, 0, 0);
    txn("R5 eral x8 12",   3'd3, 1'b0, 12, 0, 0, 0, 1);
    txn("R5 eral x16 11",  3'd3, 1'b1, 11, 0, 0, 0, 0);
    txn("R7 erase x16 12", 3'd2, 1'b1, 12, 0, 0, 0, 0);
    txn("R6 wral x8 20",   3'd4, 1'b0, 20, 0, 0, 0, 0);
    txn("R6 wral x16 27",  3'd4, 1'b1, 27, 0, 0, 0, 0);
    txn("R8 read 20",      3'd0, 1'b0, 20, 0, 0, 0, 0);
    txn("R8 class5",       3'd5, 1'b1, 27, 0, 0, 0, 0);
    txn("R8 class7",       3'd7, 1'b0, 12, 0, 0, 0, 0);
    txn("R9 sat 59",       3'd1, 1'b1, 59, 0, 0, 0, 0);
    txn("R9 sat 40",       3'd4, 1'b0, 40, 0, 0, 0, 0);
    txn("R11 merged 20",   3'd1, 1'b0, 20, 1, 0, 0, 0);
    txn("R11 merged 26",   3'd1, 1'b1, 26, 1, 0, 0, 0);
    txn("R11 merged 11",   3'd2, 1'b1, 11, 1, 0, 0, 0);
    txn("R10 start on rise", 3'd1, 1'b0, 20, 0, 1, 0, 0);
    txn("R2 pre-start edges", 3'd1, 1'b0, 20, 0, 0, 7, 0);

    // R10: clear on chip-select rise; later edges must not count without a start.
    instr_cls = 3'd1; org_x16 = 1'b0;
    drive(1'b0, 1'b1, 1'b0, 1'b0);
    drive(1'b1, 1'b0, 1'b0, 1'b1);
    repeat (9) drive(1'b1, 1'b0, 1'b0, 1'b0);
    drive(1'b0, 1'b1, 1'b0, 1'b0);
    repeat (10) drive(1'b1, 1'b0, 1'b0, 1'b0);
    drive(1'b0, 1'b0, 1'b1, 1'b0);
    chk("R10 clear on rise", {exec_permit, exec_reject}, 2'b01);
    drive(1'b0, 1'b0, 1'b0, 1'b0);

    // R2: edges after the fall are not counted into the next verdict.
    drive(1'b0, 1'b1, 1'b0, 1'b0);
    drive(1'b1, 1'b0, 1'b0, 1'b1);
    repeat (18) drive(1'b1, 1'b0, 1'b0, 1'b0);
    drive(1'b0, 1'b0, 1'b1, 1'b0);
    chk("R2 19 edges", {exec_permit, exec_reject}, 2'b01);
    drive(1'b1, 1'b0, 1'b0, 1'b0);
    drive(1'b0, 1'b0, 1'b1, 1'b0);
    chk("R2 edge after fall ignored", {exec_permit, exec_reject}, 2'b01);
    drive(1'b0, 1'b0, 1'b0, 1'b0);

    for (int k = 0; k < 300; k++) begin
      logic [2:0] c;
      logic       o;
      int         base;
      int         n;
      c = 3'($urandom_range(0, 7));
      o = 1'($urandom_range(0, 1));
      base = (c == 3'd2 || c == 3'd3) ? (o ? 11 : 12) : (o ? 27 : 20);
      n = base + $urandom_range(0, 4) - 2;
      if ($urandom_range(0, 9) == 0) n = $urandom_range(1, 70);
      txn("R7 random", c, o, n, bit'($urandom_range(0, 1)) && (n > 1),
          bit'($urandom_range(0, 3) == 0), $urandom_range(0, 3), 1'b1);
    end

    done = 1'b1;
    summary();
    $finish;
  end
endmodule